// File: doc/BRIEF.md
# Disk Read DMA Sequencer

This block carries out a disk read transfer into memory. The register unit gives it a one-cycle start pulse together with three values: the 18-bit memory start address, the packed start position on the medium, and a two's-complement word count. The block turns the start position into a linear byte offset on the medium. It issues one request for that offset and byte count on a request channel, and then takes the bytes from a valid/ready byte stream. Each byte is written to memory through a byte-write master port that waits for an acknowledge.

While the data moves, the block keeps track of the position on the medium. Each time a whole sector has been written, it steps to the next sector. When the sector number passes the last sector it wraps and the head changes, and after the second head the cylinder steps. A final sector that is only partly read leaves the position where it is. When the last byte is acknowledged, a one-cycle completion pulse goes out. An interrupt request goes out with it if interrupts were enabled at start time.

Top module: `diskReadSeq`

## Requirements
- R1: During reset and after it, `busy`, `reqValid`, `memReq`, `dinReady`, `done` and `irqReq` are low until a start pulse arrives.
- R2: A start pulse while idle makes `busy` go high in the next cycle. `busy` stays high up to and including the cycle in which `done` is high, and is low in the cycle after.
- R3: A start pulse while `busy` is high is ignored. The request values, the memory addresses, the byte count and the final position all stay those of the transfer already running.
- R4: `reqByteCount` equals 2 × (65536 − `wordCount`), as an 18-bit value. `reqValid` stays high with steady values until a cycle in which `reqReady` is high.
- R5: The start position is decoded from `diskAddr` as sector = bits 5:0, head = bit 6, cylinder = bits 15:7. `reqOffset` equals ((cylinder × 2 + head) × SPT + sector) × BPS.
- R6: `dinReady` is high only after the request is accepted and while no memory write is pending. Each accepted stream byte produces exactly one memory write carrying that byte.
- R7: The first write goes to address {`busAddrHi`, `busAddr`}, and each acknowledged write moves the address up by one, modulo 2^18. `memReq`, `memAddr` and `memData` hold steady until `memAck`.
- R8: `curDiskAddr` shows the current position in the same layout as `diskAddr`. After each whole sector, the sector number increments. Past sector SPT−1 it becomes 0 and the head toggles, and when the head wraps from 1 to 0 the cylinder increments.
- R9: A final sector that is only partly transferred ends the transfer without changing the position.
- R10: `done` is a one-cycle pulse in the cycle after the last byte's acknowledge. `irqReq` is high in that same cycle only if `intEnable` was high with the start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle start pulse from the register unit |
| busAddrHi | input | 2 | Upper two bits of the 18-bit memory start address |
| busAddr | input | 16 | Lower 16 bits of the memory start address |
| diskAddr | input | 16 | Start position: sector 5:0, head 6, cylinder 15:7 |
| wordCount | input | 16 | Two's-complement word count |
| intEnable | input | 1 | Interrupt enable, captured at start |
| reqValid | output | 1 | Read request to the disk data source |
| reqOffset | output | OFS_W | Linear byte offset on the medium |
| reqByteCount | output | 18 | Number of bytes requested |
| reqReady | input | 1 | Request accepted |
| dinValid | input | 1 | Stream byte valid |
| dinData | input | 8 | Stream byte |
| dinReady | output | 1 | Sequencer can take a stream byte |
| memReq | output | 1 | Memory byte-write request |
| memAddr | output | 18 | Memory byte address |
| memData | output | 8 | Byte to write |
| memAck | input | 1 | Memory write acknowledge |
| curDiskAddr | output | 16 | Current position on the medium, same layout as diskAddr |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Completion pulse |
| irqReq | output | 1 | Interrupt request pulse |

## Verification
Two things can happen in the same clock edge: the memory acknowledge of the last byte of a sector, which steps the position, and the end of the transfer, which raises `done`. The bench provokes this with one transfer that ends exactly on a sector boundary and another that ends partway through a sector. It then checks `curDiskAddr` in the `done` cycle: the position must have stepped in the first case and stayed where it was in the second. A second overlap is a start pulse that arrives while the request is still pending. This is judged by the request values staying the same and by the scoreboard seeing only the first transfer's writes.

// File: rtl/drs_pkg.sv
package drs_pkg;
  localparam int ADDR_W = 18;
  localparam int CNT_W  = 18;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_XFER,
    ST_WRITE,
    ST_FIN
  } drsState_t;

  typedef struct packed {
    logic load;     // capture start values
    logic capture;  // take a stream byte
    logic advance;  // memory write acknowledged
  } drsStrobe_t;
endpackage

// File: rtl/drs_datapath.sv
module drs_datapath
  import drs_pkg::*;
#(
  parameter int SPT   = 40,
  parameter int BPS   = 256,
  parameter int OFS_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  drsStrobe_t        strobe,
  input  logic [1:0]        busAddrHi,
  input  logic [15:0]       busAddr,
  input  logic [15:0]       diskAddr,
  input  logic [15:0]       wordCount,
  input  logic [7:0]        dinData,
  output logic [OFS_W-1:0]  reqOffset,
  output logic [CNT_W-1:0]  reqByteCount,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memData,
  output logic [15:0]       curDiskAddr,
  output logic              lastByte
);
  localparam int BYTE_W = (BPS > 1) ? $clog2(BPS) : 1;
  localparam logic [BYTE_W-1:0] BYTE_LAST = BYTE_W'(BPS - 1);
  localparam logic [5:0]        SEC_LAST  = 6'(SPT - 1);

  logic [ADDR_W-1:0] addrQ;
  logic [CNT_W-1:0]  remQ, countQ;
  logic [BYTE_W-1:0] byteQ;
  logic [5:0]        secQ, secNext;
  logic              headQ, headNext;
  logic [8:0]        cylQ, cylNext;
  logic [7:0]        dataQ;
  logic [OFS_W-1:0]  offsetQ;

  // start offset from the packed position
  logic [OFS_W-1:0] trackIdx, sectorIdx, offsetCalc;
  logic [16:0]      wordsCalc;
  assign trackIdx   = OFS_W'(diskAddr[15:7]) * OFS_W'(2) + OFS_W'(diskAddr[6]);
  assign sectorIdx  = trackIdx * OFS_W'(SPT) + OFS_W'(diskAddr[5:0]);
  assign offsetCalc = sectorIdx * OFS_W'(BPS);
  assign wordsCalc  = 17'h10000 - {1'b0, wordCount};

  // nested wrap: sector, then head, then cylinder
  always_comb begin
    secNext  = secQ + 6'd1;
    headNext = headQ;
    cylNext  = cylQ;
    if (secQ == SEC_LAST) begin
      secNext  = 6'd0;
      headNext = ~headQ;
      if (headQ) cylNext = cylQ + 9'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addrQ   <= '0;
      remQ    <= '0;
      countQ  <= '0;
      byteQ   <= '0;
      secQ    <= '0;
      headQ   <= 1'b0;
      cylQ    <= '0;
      dataQ   <= '0;
      offsetQ <= '0;
    end else if (strobe.load) begin
      addrQ   <= {busAddrHi, busAddr};
      remQ    <= {wordsCalc, 1'b0};
      countQ  <= {wordsCalc, 1'b0};
      byteQ   <= '0;
      secQ    <= diskAddr[5:0];
      headQ   <= diskAddr[6];
      cylQ    <= diskAddr[15:7];
      offsetQ <= offsetCalc;
    end else begin
      if (strobe.capture) dataQ <= dinData;
      if (strobe.advance) begin
        addrQ <= addrQ + ADDR_W'(1);
        remQ  <= remQ - CNT_W'(1);
        if (byteQ == BYTE_LAST) begin
          byteQ <= '0;
          secQ  <= secNext;
          headQ <= headNext;
          cylQ  <= cylNext;
        end else begin
          byteQ <= byteQ + BYTE_W'(1);
        end
      end
    end
  end

  assign reqOffset    = offsetQ;
  assign reqByteCount = countQ;
  assign memAddr      = addrQ;
  assign memData      = dataQ;
  assign curDiskAddr  = {cylQ, headQ, secQ};
  assign lastByte     = (remQ == CNT_W'(1));
endmodule

// File: rtl/drs_ctrl.sv
module drs_ctrl
  import drs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       intEnable,
  input  logic       reqReady,
  input  logic       dinValid,
  input  logic       memAck,
  input  logic       lastByte,
  output drsStrobe_t strobe,
  output logic       busy,
  output logic       reqValid,
  output logic       dinReady,
  output logic       memReq,
  output logic       done,
  output logic       irqReq
);
  drsState_t stateQ, stateNext;
  logic      ieQ;

  always_comb begin
    stateNext = stateQ;
    unique case (stateQ)
      ST_IDLE:  if (start)    stateNext = ST_REQ;
      ST_REQ:   if (reqReady) stateNext = ST_XFER;
      ST_XFER:  if (dinValid) stateNext = ST_WRITE;
      ST_WRITE: if (memAck)   stateNext = lastByte ? ST_FIN : ST_XFER;
      ST_FIN:                 stateNext = ST_IDLE;
      default:                stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stateQ <= ST_IDLE;
      ieQ    <= 1'b0;
    end else begin
      stateQ <= stateNext;
      if (stateQ == ST_IDLE && start) ieQ <= intEnable;
    end
  end

  assign strobe.load    = (stateQ == ST_IDLE)  && start;
  assign strobe.capture = (stateQ == ST_XFER)  && dinValid;
  assign strobe.advance = (stateQ == ST_WRITE) && memAck;

  assign busy     = (stateQ != ST_IDLE);
  assign reqValid = (stateQ == ST_REQ);
  assign dinReady = (stateQ == ST_XFER);
  assign memReq   = (stateQ == ST_WRITE);
  assign done     = (stateQ == ST_FIN);
  assign irqReq   = done && ieQ;
endmodule

// File: rtl/diskReadSeq.sv
module diskReadSeq
  import drs_pkg::*;
#(
  parameter int SPT   = 40,
  parameter int BPS   = 256,
  parameter int OFS_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        busAddrHi,
  input  logic [15:0]       busAddr,
  input  logic [15:0]       diskAddr,
  input  logic [15:0]       wordCount,
  input  logic              intEnable,
  output logic              reqValid,
  output logic [OFS_W-1:0]  reqOffset,
  output logic [17:0]       reqByteCount,
  input  logic              reqReady,
  input  logic              dinValid,
  input  logic [7:0]        dinData,
  output logic              dinReady,
  output logic              memReq,
  output logic [17:0]       memAddr,
  output logic [7:0]        memData,
  input  logic              memAck,
  output logic [15:0]       curDiskAddr,
  output logic              busy,
  output logic              done,
  output logic              irqReq
);
  drsStrobe_t strobe;
  logic       lastByte;

  drs_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .intEnable(intEnable),
    .reqReady(reqReady), .dinValid(dinValid), .memAck(memAck),
    .lastByte(lastByte), .strobe(strobe), .busy(busy),
    .reqValid(reqValid), .dinReady(dinReady), .memReq(memReq),
    .done(done), .irqReq(irqReq)
  );

  drs_datapath #(.SPT(SPT), .BPS(BPS), .OFS_W(OFS_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .busAddrHi(busAddrHi),
    .busAddr(busAddr), .diskAddr(diskAddr), .wordCount(wordCount),
    .dinData(dinData), .reqOffset(reqOffset), .reqByteCount(reqByteCount),
    .memAddr(memAddr), .memData(memData), .curDiskAddr(curDiskAddr),
    .lastByte(lastByte)
  );
endmodule

// File: rtl/drs_checker.sv
module drs_checker #(
  parameter int OFS_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             reqValid,
  input logic             reqReady,
  input logic [OFS_W-1:0] reqOffset,
  input logic [17:0]      reqByteCount,
  input logic             dinReady,
  input logic             memReq,
  input logic             memAck,
  input logic [17:0]      memAddr,
  input logic [7:0]       memData,
  input logic [15:0]      curDiskAddr,
  input logic             done,
  input logic             irqReq
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !reqValid && !memReq && !dinReady && !done);

  a_r2_busy_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start |=> busy);

  a_r3_values_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(reqOffset) && $stable(reqByteCount));

  a_r4_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid && !reqReady |=> reqValid && $stable(reqOffset) && $stable(reqByteCount));

  a_r6_no_ready_while_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(memReq && dinReady));

  a_r7_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memData));

  a_r7_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    memReq && memAck |=> memAddr == $past(memAddr) + 18'd1);

  a_r8_pos_only_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !(memReq && memAck) |=> $stable(curDiskAddr));

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  a_r10_irq_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    irqReq |-> done && busy);
endmodule

bind diskReadSeq drs_checker #(.OFS_W(OFS_W)) u_drs_checker (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .reqValid(reqValid), .reqReady(reqReady), .reqOffset(reqOffset),
  .reqByteCount(reqByteCount), .dinReady(dinReady), .memReq(memReq),
  .memAck(memAck), .memAddr(memAddr), .memData(memData),
  .curDiskAddr(curDiskAddr), .done(done), .irqReq(irqReq)
);

// File: tb/diskReadSeq_bench.sv
module diskReadSeq_bench;
  localparam int SPT = 3;
  localparam int BPS = 4;
  localparam int OFS_W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] busAddrHi = '0;
  logic [15:0] busAddr = '0, diskAddr = '0, wordCount = '0;
  logic intEnable = 1'b0;
  logic reqValid, reqReady = 1'b0;
  logic [OFS_W-1:0] reqOffset;
  logic [17:0] reqByteCount;
  logic dinValid = 1'b0;
  logic [7:0] dinData = '0;
  logic dinReady, memReq, memAck = 1'b0;
  logic [17:0] memAddr;
  logic [7:0] memData;
  logic [15:0] curDiskAddr;
  logic busy, done, irqReq;

  int nChecks = 0;
  int nFails = 0;
  int ackStall = 0;
  logic [25:0] expQ[$];  // {addr, data}

  always #5 clk = ~clk;

  diskReadSeq #(.SPT(SPT), .BPS(BPS), .OFS_W(OFS_W)) u_diskReadSeq (
    .clk(clk), .rst_n(rst_n), .start(start), .busAddrHi(busAddrHi),
    .busAddr(busAddr), .diskAddr(diskAddr), .wordCount(wordCount),
    .intEnable(intEnable), .reqValid(reqValid), .reqOffset(reqOffset),
    .reqByteCount(reqByteCount), .reqReady(reqReady), .dinValid(dinValid),
    .dinData(dinData), .dinReady(dinReady), .memReq(memReq),
    .memAddr(memAddr), .memData(memData), .memAck(memAck),
    .curDiskAddr(curDiskAddr), .busy(busy), .done(done), .irqReq(irqReq)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] stepPos(input logic [15:0] p);
    logic [5:0] s; logic h; logic [8:0] c;
    s = p[5:0]; h = p[6]; c = p[15:7];
    if (int'(s) == SPT - 1) begin
      s = 0;
      if (h) c = c + 9'd1;
      h = ~h;
    end else s = s + 6'd1;
    return {c, h, s};
  endfunction

  // monitor: compares each memory write with the scoreboard and acknowledges it
  initial begin
    forever begin
      @(negedge clk);
      memAck = 1'b0;
      if (memReq) begin
        logic [25:0] exp;
        check(!dinReady, "R6", "dinReady during write", dinReady, 0);
        if (expQ.size() == 0) begin
          check(1'b0, "R6", "unexpected write", {memAddr, memData}, 0);
        end else begin
          exp = expQ.pop_front();
          check(memAddr == exp[25:8], "R7", "write address", memAddr, exp[25:8]);
          check(memData == exp[7:0], "R6", "write data", memData, exp[7:0]);
        end
        repeat (ackStall) @(negedge clk);
        memAck = 1'b1;
      end
    end
  end

  // driver: one complete transfer
  task automatic runXfer(input logic [1:0] hi, input logic [15:0] ba,
                         input logic [15:0] da, input logic [15:0] wc,
                         input logic ie, input int reqDelay, input bit poke);
    int nBytes;
    longint expOfs;
    logic [15:0] pos;
    logic [17:0] base;
    nBytes = 2 * (65536 - int'(wc));
    expOfs = ((longint'(da[15:7]) * 2 + da[6]) * SPT + da[5:0]) * BPS;
    base = {hi, ba};
    pos = da;
    for (int i = 0; i < nBytes; i++) begin
      expQ.push_back({base + 18'(i), 8'(i * 13 + int'(da[7:0]))});
      if (i % BPS == BPS - 1) pos = stepPos(pos);
    end

    busAddrHi = hi; busAddr = ba; diskAddr = da; wordCount = wc; intEnable = ie;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy, "R2", "busy after start", busy, 1);
    for (int t = 0; t < 20 && !reqValid; t++) @(negedge clk);
    check(reqValid, "R4", "request raised", reqValid, 1);
    check(reqByteCount == 18'(nBytes), "R4", "byte count", reqByteCount, nBytes);
    check(reqOffset == OFS_W'(expOfs), "R5", "media offset", reqOffset, expOfs);
    check(curDiskAddr == da, "R8", "start position", curDiskAddr, da);
    if (poke) begin
      busAddrHi = 2'd3; busAddr = 16'h4444; diskAddr = 16'h0ABC;
      wordCount = 16'hFFF0; intEnable = ~ie;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(reqByteCount == 18'(nBytes), "R3", "count after busy start", reqByteCount, nBytes);
      check(reqOffset == OFS_W'(expOfs), "R3", "offset after busy start", reqOffset, expOfs);
      intEnable = ie;
    end
    repeat (reqDelay) @(negedge clk);
    check(reqValid, "R4", "request held", reqValid, 1);
    reqReady = 1'b1;
    @(negedge clk);
    reqReady = 1'b0;
    for (int i = 0; i < nBytes; i++) begin
      dinValid = 1'b1;
      dinData = 8'(i * 13 + int'(da[7:0]));
      for (int t = 0; t < 50 && !dinReady; t++) @(negedge clk);
      @(negedge clk);
    end
    dinValid = 1'b0;
    for (int t = 0; t < 50 && !done; t++) @(negedge clk);
    check(done, "R10", "done pulse", done, 1);
    check(busy, "R2", "busy in done cycle", busy, 1);
    check(irqReq == ie, "R10", "irq request", irqReq, ie);
    check(curDiskAddr == pos, (nBytes % BPS != 0) ? "R9" : "R8",
          "final position", curDiskAddr, pos);
    check(expQ.size() == 0, "R6", "writes outstanding", expQ.size(), 0);
    @(negedge clk);
    check(!done && !busy, "R2", "idle after done", {done, busy}, 0);
    check(!irqReq, "R10", "irq cleared", irqReq, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !reqValid && !memReq && !dinReady && !done && !irqReq,
          "R1", "reset outputs", {busy, reqValid, memReq, dinReady, done, irqReq}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !reqValid && !memReq && !done, "R1", "idle after reset",
          {busy, reqValid, memReq, done}, 0);

    // three whole sectors, sector and head wrap (R8)
    ackStall = 0;
    runXfer(2'd0, 16'h1000, {9'd5, 1'b0, 6'd1}, 16'hFFFA, 1'b1, 2, 1'b0);
    // one whole sector then a partial one, cylinder step and address carry (R7, R9)
    ackStall = 2;
    runXfer(2'd1, 16'hFFFE, {9'd7, 1'b1, 6'd2}, 16'hFFFD, 1'b0, 0, 1'b0);
    // partial only, with a start while busy (R3, R9)
    ackStall = 1;
    runXfer(2'd2, 16'h0100, {9'd0, 1'b0, 6'd0}, 16'hFFFF, 1'b1, 3, 1'b1);
    // ends exactly on a sector boundary (R8, R10)
    ackStall = 0;
    runXfer(2'd0, 16'h2000, {9'd9, 1'b0, 6'd2}, 16'hFFFE, 1'b1, 1, 1'b0);

    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL R2 watchdog: actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule